// File: doc/BRIEF.md
# Bayer Horizontal Defect Pixel Corrector

This block sits in a raw-image pipeline and repairs isolated stuck or hot pixels in a stream of 10-bit Bayer samples. It works one line at a time. For each pixel it looks at the two nearest samples of the same colour. In a Bayer line the colours alternate, so these sit two positions to the left and two to the right. If the pixel is brighter than both of them, or darker than both, by more than a programmable margin, it is replaced by the truncated mean of those two samples. Otherwise it leaves the block untouched.

Pixels arrive with a valid strobe and a line-start flag. Each pixel leaves the block two accepted pixels later, with its line-start flag. A pixel that lacks a full neighbourhood inside its own line is never changed. This applies to the first two and the last two pixels of every line. Correction is switched off after reset, and the margin resets to 20. Each setting is loaded by its own strobe. When correction is off, the stream passes through with the same timing.

Top module: `bayer_spot_fix`

## Requirements
- R1: After reset `out_valid` is 0, correction is off and the margin is 20.
- R2: A pixel accepted on one clock edge (`in_valid`=1) is presented on `out_valid`/`out_pix` in the cycle following the edge that accepts the pixel two valid positions later. `out_valid` is high only in cycles following an edge with `in_valid`=1, and idle cycles between pixels do not change the result.
- R3: With correction on, when both same-colour neighbours (positions -2 and +2 in the line) exceed the pixel by more than the margin, the output is (left+right)>>1, truncated.
- R4: With correction on, when the pixel exceeds both neighbours by more than the margin, the output is (left+right)>>1, truncated.
- R5: A pixel whose difference from either neighbour equals the margin, or that lies between its neighbours, is output unchanged. Both comparisons are strictly greater-than.
- R6: The first two and last two pixels of a line are output unchanged whatever their values. A line starts at the pixel accepted with `in_sol`=1, and the previous line ends just before it.
- R7: With correction off, every pixel is output unchanged with the R2 latency.
- R8: `en_load`=1 loads `en_value` as the correction switch, and `th_load`=1 loads the 7-bit `th_value` as the margin. Each takes effect for outputs formed at later clock edges.
- R9: `out_sol` accompanies each output pixel and equals the `in_sol` it was accepted with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel strobe |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_pix | input | 10 | Input raw pixel |
| en_load | input | 1 | Load strobe for the correction switch |
| en_value | input | 1 | New correction switch value |
| th_load | input | 1 | Load strobe for the margin |
| th_value | input | 7 | New margin value |
| out_valid | output | 1 | Output pixel strobe |
| out_sol | output | 1 | Output pixel is the first of a line |
| out_pix | output | 10 | Output (possibly corrected) pixel |

## Verification
Several patterns are driven, and each one separates a different part of the behaviour:
- A flat line with a single spike and a single dip separates the high and low repair paths.
- Differences of exactly the margin and of the margin plus one expose a non-strict comparison.
- A pixel that lies between two unequal neighbours catches a detector that looks at only one side.
- Full-scale extremes catch overflow in the averaging sum and wrong rounding of an odd sum.
- Outliers placed at the two ends of short lines, including lines shorter than five pixels, show whether line boundaries are respected.
- Gapped strobes, random lines and margin changes compare latency and correction against a behavioural model on every clock.

// File: rtl/bpr_pkg.sv
// Shared constants and types for the Bayer horizontal defect corrector.
// Assumes a Bayer line where same-colour samples repeat every BPR_DIST pixels.
package bpr_pkg;
    localparam int unsigned BPR_DIST = 2;
    localparam int unsigned BPR_TAPS = 2 * BPR_DIST + 1;

    typedef enum logic [2:0] {
        DEC_PASS_OFF,
        DEC_PASS_EDGE,
        DEC_PASS_NEAR,
        DEC_FIX_LOW,
        DEC_FIX_HIGH
    } bpr_dec_e;
endpackage

// File: rtl/bpr_cfg.sv
// Holds the correction switch and the detection margin.
// Each value loads from its own strobe; reset gives switch off and margin TH_RST.
module bpr_cfg #(
    parameter int unsigned TH_W   = 7,
    parameter int unsigned TH_RST = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_load,
    input  logic            en_value,
    input  logic            th_load,
    input  logic [TH_W-1:0] th_value,
    output logic            en_q,
    output logic [TH_W-1:0] th_q
);
    // switch register, loaded on its strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (en_load) en_q <= en_value;
    end

    // margin register, loaded on its strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       th_q <= TH_W'(TH_RST);
        else if (th_load) th_q <= th_value;
    end
endmodule

// File: rtl/bpr_taps.sv
// Pixel window of TAPS entries; tap 0 is the newest.
// nxt_* present the window as it will be after the current pixel is shifted in;
// cur_* present the registered window. A line-start flag is kept for all taps but
// the oldest, whose flag never affects a decision.
module bpr_taps #(
    parameter int unsigned PIX_W = 10,
    parameter int unsigned TAPS  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_sol,
    output logic [PIX_W-1:0] nxt_lft,
    output logic [PIX_W-1:0] nxt_ctr,
    output logic [PIX_W-1:0] nxt_rgt,
    output logic [TAPS-2:0]  nxt_sol,
    output logic [TAPS-1:0]  nxt_full,
    output logic [PIX_W-1:0] cur_lft,
    output logic [PIX_W-1:0] cur_ctr,
    output logic [PIX_W-1:0] cur_rgt,
    output logic [TAPS-2:0]  cur_sol,
    output logic [TAPS-1:0]  cur_full
);
    localparam int unsigned CTR = TAPS / 2;

    logic [PIX_W-1:0] tap_pix [TAPS];
    logic [PIX_W-1:0] nxt_pix [TAPS];
    logic [TAPS-2:0]  tap_sol;
    logic [TAPS-1:0]  tap_full;

    genvar k;
    generate
        for (k = 0; k < TAPS; k++) begin : g_tap
            if (k == 0) begin : g_head
                assign nxt_pix[k]  = in_pix;
                assign nxt_full[k] = 1'b1;
                assign nxt_sol[k]  = in_sol;
            end else begin : g_body
                assign nxt_pix[k]  = tap_pix[k-1];
                assign nxt_full[k] = tap_full[k-1];
                if (k < TAPS - 1) begin : g_flag
                    assign nxt_sol[k] = tap_sol[k-1];
                end
            end

            // pixel and fill state of tap k, advanced on each accepted pixel
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tap_pix[k]  <= '0;
                    tap_full[k] <= 1'b0;
                end else if (shift) begin
                    tap_pix[k]  <= nxt_pix[k];
                    tap_full[k] <= nxt_full[k];
                end
            end

            if (k < TAPS - 1) begin : g_solreg
                // line-start flag of tap k
                always_ff @(posedge clk) begin
                    if (!rst_n)     tap_sol[k] <= 1'b0;
                    else if (shift) tap_sol[k] <= nxt_sol[k];
                end
            end
        end
    endgenerate

    assign nxt_lft  = nxt_pix[TAPS-1];
    assign nxt_ctr  = nxt_pix[CTR];
    assign nxt_rgt  = nxt_pix[0];
    assign cur_lft  = tap_pix[TAPS-1];
    assign cur_ctr  = tap_pix[CTR];
    assign cur_rgt  = tap_pix[0];
    assign cur_sol  = tap_sol;
    assign cur_full = tap_full;
endmodule

// File: rtl/bpr_judge.sv
// Combinational outlier decision and repair for the centre pixel.
// Assumes the window is valid only when every tap is filled and no tap other than
// the oldest starts a line; otherwise the centre is passed unchanged.
module bpr_judge
    import bpr_pkg::*;
#(
    parameter int unsigned PIX_W = 10,
    parameter int unsigned TH_W  = 7,
    parameter int unsigned TAPS  = 5
) (
    input  logic [PIX_W-1:0] lft,
    input  logic [PIX_W-1:0] ctr,
    input  logic [PIX_W-1:0] rgt,
    input  logic [TAPS-2:0]  sol,
    input  logic [TAPS-1:0]  full,
    input  logic             en,
    input  logic [TH_W-1:0]  th,
    output logic [PIX_W-1:0] res_pix,
    output bpr_dec_e         dec
);
    logic [PIX_W-1:0] th_ext;
    logic [PIX_W:0]   pair_sum;
    logic [PIX_W-1:0] pair_avg;
    logic             nbh_ok;
    logic             low_l, low_r, high_l, high_r;

    assign th_ext   = PIX_W'(th);
    assign pair_sum = {1'b0, lft} + {1'b0, rgt};
    assign pair_avg = pair_sum[PIX_W:1];
    assign nbh_ok   = (&full) && !(|sol);

    // strict margin tests against each neighbour
    always_comb begin
        low_l  = (lft > ctr) && ((lft - ctr) > th_ext);
        low_r  = (rgt > ctr) && ((rgt - ctr) > th_ext);
        high_l = (ctr > lft) && ((ctr - lft) > th_ext);
        high_r = (ctr > rgt) && ((ctr - rgt) > th_ext);
    end

    // choose the decision and the output sample
    always_comb begin
        if (!en)                  dec = DEC_PASS_OFF;
        else if (!nbh_ok)         dec = DEC_PASS_EDGE;
        else if (low_l && low_r)  dec = DEC_FIX_LOW;
        else if (high_l && high_r) dec = DEC_FIX_HIGH;
        else                      dec = DEC_PASS_NEAR;
        res_pix = ((dec == DEC_FIX_LOW) || (dec == DEC_FIX_HIGH)) ? pair_avg : ctr;
    end
endmodule

// File: rtl/bayer_spot_fix.sv
// Top of the Bayer horizontal defect corrector.
// Each accepted pixel leaves the block after the pixel two valid positions later has
// been accepted; the output is registered at that edge.
module bayer_spot_fix
    import bpr_pkg::*;
#(
    parameter int unsigned PIX_W  = 10,
    parameter int unsigned TH_W   = 7,
    parameter int unsigned TH_RST = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             en_load,
    input  logic             en_value,
    input  logic             th_load,
    input  logic [TH_W-1:0]  th_value,
    output logic             out_valid,
    output logic             out_sol,
    output logic [PIX_W-1:0] out_pix
);
    localparam int unsigned TAPS = BPR_TAPS;
    localparam int unsigned CTR  = TAPS / 2;

    logic             en_q;
    logic [TH_W-1:0]  th_q;
    logic [PIX_W-1:0] nxt_lft, nxt_ctr, nxt_rgt;
    logic [TAPS-2:0]  nxt_sol;
    logic [TAPS-1:0]  nxt_full;
    logic [PIX_W-1:0] cur_lft, cur_ctr, cur_rgt;
    logic [TAPS-2:0]  cur_sol;
    logic [TAPS-1:0]  cur_full;
    logic [PIX_W-1:0] res_pix;
    bpr_dec_e         dec;

    bpr_cfg #(.TH_W(TH_W), .TH_RST(TH_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .en_load(en_load), .en_value(en_value),
        .th_load(th_load), .th_value(th_value),
        .en_q(en_q), .th_q(th_q)
    );

    bpr_taps #(.PIX_W(PIX_W), .TAPS(TAPS)) u_taps (
        .clk(clk), .rst_n(rst_n), .shift(in_valid),
        .in_pix(in_pix), .in_sol(in_sol),
        .nxt_lft(nxt_lft), .nxt_ctr(nxt_ctr), .nxt_rgt(nxt_rgt),
        .nxt_sol(nxt_sol), .nxt_full(nxt_full),
        .cur_lft(cur_lft), .cur_ctr(cur_ctr), .cur_rgt(cur_rgt),
        .cur_sol(cur_sol), .cur_full(cur_full)
    );

    bpr_judge #(.PIX_W(PIX_W), .TH_W(TH_W), .TAPS(TAPS)) u_judge (
        .lft(nxt_lft), .ctr(nxt_ctr), .rgt(nxt_rgt),
        .sol(nxt_sol), .full(nxt_full),
        .en(en_q), .th(th_q),
        .res_pix(res_pix), .dec(dec)
    );

    // output register: strobe when the centre tap becomes filled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid && nxt_full[CTR];
            if (in_valid) begin
                out_sol <= nxt_sol[CTR];
                out_pix <= res_pix;
            end
        end
    end
endmodule

// File: rtl/bayer_spot_fix_chk.sv
// Property checker for bayer_spot_fix, attached by bind.
// Relates the registered output to the registered window, which holds the same
// pixels the output was formed from.
module bayer_spot_fix_chk #(
    parameter int unsigned PIX_W  = 10,
    parameter int unsigned TH_W   = 7,
    parameter int unsigned TH_RST = 20,
    parameter int unsigned TAPS   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_sol,
    input logic [PIX_W-1:0] out_pix,
    input logic             en_q,
    input logic [TH_W-1:0]  th_q,
    input logic [PIX_W-1:0] cur_lft,
    input logic [PIX_W-1:0] cur_ctr,
    input logic [PIX_W-1:0] cur_rgt,
    input logic [TAPS-2:0]  cur_sol,
    input logic [TAPS-1:0]  cur_full
);
    localparam int unsigned CTR = TAPS / 2;

    logic [PIX_W-1:0] nb_lo, nb_hi;
    assign nb_lo = (cur_lft < cur_rgt) ? cur_lft : cur_rgt;
    assign nb_hi = (cur_lft < cur_rgt) ? cur_rgt : cur_lft;

    AST_RESET_STATE: assert property (@(posedge clk)
        $rose(rst_n) |-> (!en_q && th_q == TH_W'(TH_RST) && !out_valid)); // R1

    AST_VALID_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R2

    AST_REPAIR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pix == cur_ctr || (out_pix >= nb_lo && out_pix <= nb_hi))); // R3

    AST_EDGE_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ((|cur_sol) || !(&cur_full))) |-> out_pix == cur_ctr); // R6

    AST_OFF_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(en_q)) |-> out_pix == cur_ctr); // R7

    AST_SOL_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sol == cur_sol[CTR] && cur_full[CTR])); // R9
endmodule

bind bayer_spot_fix bayer_spot_fix_chk #(
    .PIX_W(PIX_W), .TH_W(TH_W), .TH_RST(TH_RST), .TAPS(TAPS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .out_valid(out_valid), .out_sol(out_sol), .out_pix(out_pix),
    .en_q(en_q), .th_q(th_q),
    .cur_lft(cur_lft), .cur_ctr(cur_ctr), .cur_rgt(cur_rgt),
    .cur_sol(cur_sol), .cur_full(cur_full)
);

// File: tb/bayer_spot_fix_tb.sv
// Bench for bayer_spot_fix: a behavioural model built on queues predicts every output
// cycle; outputs are compared at each falling edge.
module bayer_spot_fix_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sol = 1'b0;
    logic [9:0] in_pix = '0;
    logic       en_load = 1'b0, en_value = 1'b0, th_load = 1'b0;
    logic [6:0] th_value = '0;
    logic       out_valid, out_sol;
    logic [9:0] out_pix;

    always #4 clk = ~clk;

    bayer_spot_fix u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
        .en_load(en_load), .en_value(en_value), .th_load(th_load), .th_value(th_value),
        .out_valid(out_valid), .out_sol(out_sol), .out_pix(out_pix)
    );

    int    checks = 0, errors = 0;
    bit    done = 0;
    int    qp[$];
    bit    qs[$];
    bit    m_en = 0;
    int    m_th = 20;
    bit    exp_v = 0, exp_s = 0;
    int    exp_p = 0;
    string exp_tag = "R2";
    string sect = "R1";

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, sect, act, expv, $time);
        end
    endtask

    // model: predict output produced by the edge that accepts this stimulus
    task automatic model_step(input bit v, input bit s, input int p);
        exp_v = 0;
        if (!rst_n) begin
            qp.delete(); qs.delete(); m_en = 0; m_th = 20;
            return;
        end
        if (v) begin
            qp.push_back(p); qs.push_back(s);
            if (qp.size() >= 3) begin
                int c = qp.size() - 3;
                bit lok = (c >= 2) && !qs[c] && !qs[c-1];
                bit rok = !qs[c+1] && !qs[c+2];
                int x = qp[c];
                exp_v = 1; exp_s = qs[c]; exp_p = x;
                if (!m_en) exp_tag = "R7";
                else if (!(lok && rok)) exp_tag = "R6";
                else begin
                    int a = qp[c-2];
                    int b = qp[c+2];
                    if (a - x > m_th && b - x > m_th) begin exp_tag = "R3"; exp_p = (a + b) / 2; end
                    else if (x - a > m_th && x - b > m_th) begin exp_tag = "R4"; exp_p = (a + b) / 2; end
                    else exp_tag = "R5";
                end
            end
        end
    endtask

    task automatic cyc(input bit v, input bit s, input int p,
                       input bit el = 0, input bit ev = 0, input bit tl = 0, input int tv = 0);
        @(negedge clk);
        chk("R2", int'(out_valid), int'(exp_v));
        if (exp_v && out_valid) begin
            chk(exp_tag, int'(out_pix), exp_p);
            chk("R9", int'(out_sol), int'(exp_s));
        end
        in_valid = v; in_sol = s; in_pix = 10'(p);
        en_load = el; en_value = ev; th_load = tl; th_value = 7'(tv);
        model_step(v, s, p);
        if (rst_n) begin
            if (el) m_en = ev;
            if (tl) m_th = tv;
        end
    endtask

    task automatic send_line(input int px[], input bit gaps = 0);
        foreach (px[i]) begin
            if (gaps) begin
                int g = $urandom_range(0, 2);
                for (int j = 0; j < g; j++) cyc(0, 0, 0);
            end
            cyc(1, (i == 0), px[i]);
        end
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(0, 0, 0);
        @(negedge clk);
        chk("R1", int'(out_valid), 0);
        rst_n = 1'b1;
        cyc(0, 0, 0);

        // R7: correction off after reset, spike and dip pass unchanged
        sect = "R7";
        send_line('{100, 100, 100, 100, 900, 100, 100, 100, 3, 100, 100, 100});

        // R8: enable with default margin 20: 21 repaired, 20 kept (R5)
        sect = "R8";
        cyc(0, 0, 0, 1, 1);
        send_line('{200, 200, 200, 200, 221, 200, 200, 200, 220, 200, 200, 200,
                    179, 200, 200, 200, 180, 200, 200, 200});

        // R3/R4/R5: unequal neighbours, mixed case, truncation and full scale
        sect = "R3";
        send_line('{1023, 500, 1022, 500, 0, 500, 1023, 500, 300, 500, 400, 500, 350, 500, 500});
        sect = "R4";
        send_line('{0, 7, 1, 7, 1023, 7, 0, 7, 60, 8, 100, 9, 10, 9});
        sect = "R5";
        send_line('{100, 0, 150, 0, 200, 0, 100, 0});

        // R8: margin 0 and 127
        sect = "R8";
        cyc(0, 0, 0, 0, 0, 1, 0);
        send_line('{50, 50, 50, 50, 51, 50, 50, 50, 49, 50, 50, 50});
        cyc(0, 0, 0, 0, 0, 1, 127);
        send_line('{300, 300, 300, 300, 428, 300, 300, 300, 427, 300, 300, 300});
        cyc(0, 0, 0, 0, 0, 1, 20);

        // R6: outliers at line ends, short lines
        sect = "R6";
        send_line('{900, 5, 100, 100, 100, 100, 100, 100, 900, 5});
        send_line('{5, 900, 5, 900, 5});
        send_line('{800, 2, 800});
        send_line('{1});
        send_line('{100, 100, 100, 1000, 100, 100, 100});

        // R2: gapped strobes, R7 again with switch off mid-stream
        sect = "R2";
        send_line('{400, 400, 400, 400, 20, 400, 400, 400, 900, 400, 400, 400}, 1);
        cyc(0, 0, 0, 1, 0);
        sect = "R7";
        send_line('{400, 400, 400, 400, 20, 400, 400, 400}, 1);
        cyc(0, 0, 0, 1, 1);

        // random lines with spikes and margin changes
        sect = "RND";
        for (int l = 0; l < 60; l++) begin
            int n = $urandom_range(1, 40);
            int px[] = new[n];
            int base = $urandom_range(0, 1023);
            foreach (px[i]) begin
                int r = $urandom_range(0, 9);
                if (r == 0) px[i] = $urandom_range(0, 1023);
                else begin
                    int t = base + $urandom_range(0, 40) - 20;
                    px[i] = (t < 0) ? 0 : ((t > 1023) ? 1023 : t);
                end
            end
            if (l % 7 == 3) cyc(0, 0, 0, 0, 0, 1, $urandom_range(0, 127));
            if (l % 11 == 5) cyc(0, 0, 0, 1, $urandom_range(0, 1));
            send_line(px, (l % 2 == 1));
        end
        cyc(1, 1, 0);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        cyc(0, 0, 0);
        cyc(0, 0, 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule